// File: doc/BRIEF.md
# Power-Fail Write-Protect and Battery Switchover Sequencer

This block supervises a battery-backed static memory. Three external comparators report the supply against three thresholds. From the lowest up these are the switchover level (about 3 V), the write-protect trip level, and the full-function level. The block resynchronises and filters these flags, then tracks the supply through four modes: normal access, write-protected, battery backup, and a post-power-up hold. The host's chip-enable, write-enable and output-enable requests reach the memory only in normal access. In every other mode writes are blocked, outputs are turned off, and any write attempt is dropped and reported.

The trip level sits below the full-function level, so the block has hysteresis. A falling supply keeps access until it crosses the trip level. A rising supply must reach the full-function level and then sit through a timed hold before access reopens. A one-time freshness seal keeps the battery disconnected until the supply first rises above the trip level. From then on the battery is selected whenever the supply is below the switchover level. Only a dedicated factory-reset input can restore the seal. Ordinary resets and power cycles leave it alone.

Top module: `pwrfail_sequencer`

## Requirements
- R1: Each supply flag passes through a two-flop synchroniser and is accepted only after its new value has held for DEBOUNCE_CYCLES consecutive cycles. A change lasting fewer cycles than that causes no mode change.
- R2: The `mode` output encodes normal=2'b00, protected=2'b01, backup=2'b10, hold=2'b11. After `rstN` is released the mode is backup, with `writeBlock` and `outDisable` both 1.
- R3: In any mode, a filtered switchover flag of 0 selects backup. Otherwise, in normal mode, a filtered trip flag of 0 selects protected. Normal mode is kept while the trip flag is 1, even when the full flag is 0.
- R4: Backup goes to protected once the switchover flag is 1. Protected goes to hold only when the trip and full flags are both 1, so hold is entered only from protected.
- R5: Hold lasts exactly RECOVERY_CYCLES cycles and then goes to normal, so normal is entered only from hold. `memCe` stays 0 throughout hold. If the full flag falls during hold, the block returns to protected.
- R6: Outside normal mode, `memCe`, `memWe` and `memOe` are 0, and `writeBlock` and `outDisable` are 1. In normal mode, `memCe` = `reqCe`, `memWe` = `reqCe & reqWe`, and `writeBlock` and `outDisable` are 0.
- R7: In normal mode, `memOe` = `reqCe & reqOe & ~reqWe`. An active write request turns the data outputs off.
- R8: When a write request (`reqCe & reqWe`) starts while the mode is not normal, `wrDropErr` is 1 for exactly one cycle, on the cycle after the request appears.
- R9: `battSealed` is set to 1 while `factoryRstN` is low. It clears once the filtered trip flag is 1, and `rstN` never changes it.
- R10: `battSel` is 1 exactly when the mode is backup and `battSealed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of sequencer, filters and timer |
| factoryRstN | input | 1 | Active-low asynchronous re-seal of the battery |
| aboveSwitch | input | 1 | Comparator: supply above switchover level |
| aboveTrip | input | 1 | Comparator: supply above write-protect trip level |
| aboveFull | input | 1 | Comparator: supply above full-function level |
| reqCe | input | 1 | Host chip-enable request, active high |
| reqWe | input | 1 | Host write-enable request, active high |
| reqOe | input | 1 | Host output-enable request, active high |
| memCe | output | 1 | Gated chip enable to memory |
| memWe | output | 1 | Gated write enable to memory |
| memOe | output | 1 | Gated output enable to memory |
| writeBlock | output | 1 | Writes blocked |
| outDisable | output | 1 | Data outputs forced high-impedance |
| battSel | output | 1 | 1 selects battery as memory supply |
| battSealed | output | 1 | Battery still under freshness seal |
| wrDropErr | output | 1 | One-cycle pulse for a dropped write |
| mode | output | 2 | Current mode code |

## Verification
A stuck or wrongly entered mode appears on `mode` and on the gating outputs in the same cycle, because the gating is combinational from the registered mode. A bad transition therefore shows up DEBOUNCE_CYCLES+3 cycles after the flag change. A miscounting hold timer changes how many cycles `mode` reads hold, so counting those cycles exposes it exactly. A seal bit that is wrongly cleared or set shows up on `battSel` the first time the mode is backup. A broken dropped-write detector shows at `wrDropErr` one cycle after the request starts, either as no pulse or as more than one.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NUM_FLAGS   = 3;
  localparam int FLAG_SWITCH = 0;
  localparam int FLAG_TRIP   = 1;
  localparam int FLAG_FULL   = 2;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_GUARD = 2'b01,
    MODE_BATT  = 2'b10,
    MODE_HOLD  = 2'b11
  } seqMode_e;

  typedef struct packed {
    logic holdTimerRun;
    logic accessOpen;
    logic onBackup;
    logic unsealReq;
  } seqStrobe_t;
endpackage

// File: rtl/flag_conditioner.sv
module flag_conditioner #(
  parameter int NUM         = 3,
  parameter int DEB_CYCLES  = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] rawFlags,
  output logic [NUM-1:0] cleanFlags
);
  localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

  for (genvar i = 0; i < NUM; i++) begin : g_flag
    logic          syncA;
    logic          syncB;
    logic          stable;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
      end else begin
        syncA <= rawFlags[i];
        syncB <= syncA;
      end
    end

    // Accept a new level only after it has differed from the held value
    // for DEB_CYCLES consecutive cycles.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stable <= 1'b0;
        cnt    <= '0;
      end else if (syncB == stable) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_CYCLES - 1)) begin
        stable <= syncB;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign cleanFlags[i] = stable;
  end
endmodule

// File: rtl/seq_control.sv
module seq_control
  import pwrseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] cleanFlags,
  input  logic                 holdDone,
  output seqMode_e             curMode,
  output seqStrobe_t           strobe
);
  seqMode_e nextMode;
  logic     okSwitch;
  logic     okTrip;
  logic     okFull;

  assign okSwitch = cleanFlags[FLAG_SWITCH];
  assign okTrip   = cleanFlags[FLAG_TRIP];
  assign okFull   = cleanFlags[FLAG_FULL];

  always_comb begin
    nextMode = curMode;
    if (!okSwitch) begin
      nextMode = MODE_BATT;
    end else begin
      unique case (curMode)
        MODE_BATT:  nextMode = MODE_GUARD;
        MODE_GUARD: if (okTrip && okFull) nextMode = MODE_HOLD;
        MODE_HOLD: begin
          if (!okTrip || !okFull) nextMode = MODE_GUARD;
          else if (holdDone)      nextMode = MODE_RUN;
        end
        MODE_RUN:   if (!okTrip) nextMode = MODE_GUARD;
        default:    nextMode = MODE_BATT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curMode <= MODE_BATT;
    else       curMode <= nextMode;
  end

  always_comb begin
    strobe.holdTimerRun = (curMode == MODE_HOLD);
    strobe.accessOpen   = (curMode == MODE_RUN);
    strobe.onBackup     = (curMode == MODE_BATT);
    strobe.unsealReq    = okTrip;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import pwrseq_pkg::*;
#(
  parameter int REC_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       factoryRstN,
  input  seqStrobe_t strobe,
  input  logic       reqCe,
  input  logic       reqWe,
  input  logic       reqOe,
  output logic       holdDone,
  output logic       memCe,
  output logic       memWe,
  output logic       memOe,
  output logic       writeBlock,
  output logic       outDisable,
  output logic       battSel,
  output logic       battSealed,
  output logic       wrDropErr
);
  localparam int TW = $clog2(REC_CYCLES + 1);

  logic [TW-1:0] holdCnt;
  logic          sealBit;
  logic          wrNow;
  logic          wrPrev;

  // Recovery hold timer
  assign holdDone = strobe.holdTimerRun && (holdCnt == TW'(REC_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     holdCnt <= '0;
    else if (!strobe.holdTimerRun) holdCnt <= '0;
    else if (!holdDone)            holdCnt <= holdCnt + 1'b1;
  end

  // Freshness seal: only the factory input restores it
  always_ff @(posedge clk or negedge factoryRstN) begin
    if (!factoryRstN)          sealBit <= 1'b1;
    else if (strobe.unsealReq) sealBit <= 1'b0;
  end

  assign battSealed = sealBit;
  assign battSel    = strobe.onBackup && !sealBit;

  // Access gating
  assign memCe      = strobe.accessOpen && reqCe;
  assign memWe      = strobe.accessOpen && reqCe && reqWe;
  assign memOe      = strobe.accessOpen && reqCe && reqOe && !reqWe;
  assign writeBlock = !strobe.accessOpen;
  assign outDisable = !strobe.accessOpen;

  // Dropped-write detection on the start of a request
  assign wrNow = reqCe && reqWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev    <= 1'b0;
      wrDropErr <= 1'b0;
    end else begin
      wrPrev    <= wrNow;
      wrDropErr <= wrNow && !wrPrev && !strobe.accessOpen;
    end
  end
endmodule

// File: rtl/pwrfail_sequencer.sv
module pwrfail_sequencer
  import pwrseq_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 8,
  parameter int RECOVERY_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       factoryRstN,
  input  logic       aboveSwitch,
  input  logic       aboveTrip,
  input  logic       aboveFull,
  input  logic       reqCe,
  input  logic       reqWe,
  input  logic       reqOe,
  output logic       memCe,
  output logic       memWe,
  output logic       memOe,
  output logic       writeBlock,
  output logic       outDisable,
  output logic       battSel,
  output logic       battSealed,
  output logic       wrDropErr,
  output logic [1:0] mode
);
  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] cleanFlags;
  logic                 holdDone;
  seqMode_e             curMode;
  seqStrobe_t           strobe;

  always_comb begin
    rawFlags              = '0;
    rawFlags[FLAG_SWITCH] = aboveSwitch;
    rawFlags[FLAG_TRIP]   = aboveTrip;
    rawFlags[FLAG_FULL]   = aboveFull;
  end

  flag_conditioner #(.NUM(NUM_FLAGS), .DEB_CYCLES(DEBOUNCE_CYCLES)) u_cond (
    .clk(clk), .rstN(rstN), .rawFlags(rawFlags), .cleanFlags(cleanFlags)
  );

  seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .cleanFlags(cleanFlags), .holdDone(holdDone),
    .curMode(curMode), .strobe(strobe)
  );

  seq_datapath #(.REC_CYCLES(RECOVERY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .factoryRstN(factoryRstN), .strobe(strobe),
    .reqCe(reqCe), .reqWe(reqWe), .reqOe(reqOe), .holdDone(holdDone),
    .memCe(memCe), .memWe(memWe), .memOe(memOe), .writeBlock(writeBlock),
    .outDisable(outDisable), .battSel(battSel), .battSealed(battSealed),
    .wrDropErr(wrDropErr)
  );

  assign mode = curMode;
endmodule

// File: rtl/pwrfail_sequencer_chk.sv
module pwrfail_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       factoryRstN,
  input logic       reqCe,
  input logic       reqWe,
  input logic       memCe,
  input logic       memWe,
  input logic       memOe,
  input logic       writeBlock,
  input logic       outDisable,
  input logic       battSel,
  input logic       battSealed,
  input logic       wrDropErr,
  input logic [1:0] mode
);
  p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b00) |-> (!memCe && !memWe && !memOe && writeBlock && outDisable));

  p_write_hides_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && reqWe) |-> !memOe);

  p_hold_from_guard_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && $past(mode) != 2'b11) |-> ($past(mode) == 2'b01));

  p_run_from_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && $past(mode) != 2'b00) |-> ($past(mode) == 2'b11));

  p_drop_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrDropErr |-> ($past(mode) != 2'b00 && $past(reqCe && reqWe)));

  p_seal_sticky_r9: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    !battSealed |=> !battSealed);

  p_batt_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    battSel |-> (mode == 2'b10 && !battSealed));
endmodule

bind pwrfail_sequencer pwrfail_sequencer_chk u_chk (.*);

// File: tb/tb_pwrfail_sequencer.sv
`timescale 1ns/1ps
module tb_pwrfail_sequencer;
  localparam int DEB = 8;
  localparam int REC = 256;
  localparam logic [1:0] M_RUN = 2'b00, M_GUARD = 2'b01, M_BATT = 2'b10, M_HOLD = 2'b11;

  logic clk = 1'b0;
  logic rstN, factoryRstN, aboveSwitch, aboveTrip, aboveFull, reqCe, reqWe, reqOe;
  logic memCe, memWe, memOe, writeBlock, outDisable, battSel, battSealed, wrDropErr;
  logic [1:0] mode;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwrfail_sequencer #(.DEBOUNCE_CYCLES(DEB), .RECOVERY_CYCLES(REC)) dut (.*);

  // {full,trip,switch}, wait cycles, expected mode, expected battSel
  localparam logic [21:0] VEC [13] = '{
    {3'b000, 16'd40,  M_BATT,  1'b0},
    {3'b001, 16'd40,  M_GUARD, 1'b0},
    {3'b011, 16'd40,  M_GUARD, 1'b0},
    {3'b111, 16'd40,  M_HOLD,  1'b0},
    {3'b111, 16'd300, M_RUN,   1'b0},
    {3'b011, 16'd40,  M_RUN,   1'b0},
    {3'b001, 16'd40,  M_GUARD, 1'b0},
    {3'b000, 16'd40,  M_BATT,  1'b1},
    {3'b001, 16'd40,  M_GUARD, 1'b0},
    {3'b011, 16'd40,  M_GUARD, 1'b0},
    {3'b111, 16'd40,  M_HOLD,  1'b0},
    {3'b011, 16'd40,  M_GUARD, 1'b0},
    {3'b111, 16'd300, M_RUN,   1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int pulses;
    int holdLen;
    rstN = 0; factoryRstN = 0; aboveSwitch = 0; aboveTrip = 0; aboveFull = 0;
    reqCe = 0; reqWe = 0; reqOe = 0;
    repeat (5) @(negedge clk);
    factoryRstN = 1;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R2 reset mode", mode, M_BATT);
    check("R2 reset blocks", {writeBlock, outDisable}, 2'b11);
    check("R9 sealed after factory reset", battSealed, 1);
    check("R10 sealed battery off", battSel, 0);

    // R3 R4 R5 R10 table walk
    for (int i = 0; i < 13; i++) begin
      {aboveFull, aboveTrip, aboveSwitch} = VEC[i][21:19];
      repeat (int'(VEC[i][18:3])) @(negedge clk);
      check($sformatf("R3/R4/R5 row %0d mode", i), mode, VEC[i][2:1]);
      check($sformatf("R10 row %0d battSel", i), battSel, VEC[i][0]);
    end

    // R6 R7 normal access
    reqCe = 1; reqWe = 1; reqOe = 1;
    @(negedge clk);
    check("R6 normal write passes", {memCe, memWe}, 2'b11);
    check("R7 write hides output", memOe, 0);
    check("R6 normal unblocked", {writeBlock, outDisable}, 2'b00);
    pulses = 0;
    repeat (3) begin @(negedge clk); pulses += int'(wrDropErr); end
    check("R8 no error in normal", pulses, 0);
    reqWe = 0;
    @(negedge clk);
    check("R7 read enables output", memOe, 1);
    reqCe = 0; reqOe = 0;

    // R1 glitch on trip flag shorter than filter
    aboveTrip = 0;
    repeat (DEB - 4) @(negedge clk);
    aboveTrip = 1;
    repeat (20) @(negedge clk);
    check("R1 short glitch ignored", mode, M_RUN);
    aboveTrip = 0;
    repeat (DEB + 6) @(negedge clk);
    check("R1 held change accepted", mode, M_GUARD);

    // R6 R8 in protected mode
    reqCe = 1; reqWe = 1; reqOe = 1;
    pulses = 0;
    repeat (5) begin @(negedge clk); pulses += int'(wrDropErr); end
    check("R8 one error pulse", pulses, 1);
    check("R6 protected gating", {memCe, memWe, memOe, writeBlock, outDisable}, 5'b00011);
    reqWe = 0; reqOe = 0;

    // R5 exact hold length with chip enable requested
    aboveTrip = 1; aboveFull = 1;
    for (int k = 0; k < 50 && mode != M_HOLD; k++) @(negedge clk);
    check("R5 hold entered", mode, M_HOLD);
    check("R5 chip enable held off", memCe, 0);
    holdLen = 0;
    while (mode == M_HOLD && holdLen < 2 * REC) begin
      holdLen++;
      @(negedge clk);
    end
    check("R5 hold length", holdLen, REC);
    check("R5 normal after hold", mode, M_RUN);
    reqCe = 0;

    // R9 seal not restored by ordinary reset
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9 rstN keeps unsealed", battSealed, 0);
    check("R10 battery selected in backup", battSel, 1);
    factoryRstN = 0;
    @(negedge clk);
    check("R9 factory reset re-seals", battSealed, 1);
    check("R10 sealed battery off", battSel, 0);
    factoryRstN = 1;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule